// File: doc/BRIEF.md
# Prioritised Vectored Interrupt Controller

This block collects thirteen interrupt sources and presents them to an 8-bit CPU core as ten vectors with three nesting levels. Four external pins carry their own trigger logic. Nine peripheral request flags come from the timers, the serial channels, the converter and the port-change detector, and these flags are held and cleared by their owners. Several sources share a vector. Each vector has its own enable bit and a one-bit priority select. The block picks one winner. It raises a request to the CPU only when the winner's level is strictly above the level now in service.

The CPU signals entry into a handler with a one-cycle acknowledge strobe. It signals return with a one-cycle return strobe. The controller tracks the active levels internally, so a high-level handler can be pre-empted only by the top level, and a low-level handler by either of the other two. On acknowledge, the latched edge flag of the winning pin is cleared. Level requests and peripheral flags are not touched.

Top module: `irq_ctrl`

## Requirements
- R1: Vector n (0..9) has address 8*n+3, which gives 03H up to 4BH. The pins INT0, INT1, INT2 and INT3 drive vectors 0, 1, 2 and 3. The peripheral flag bits 0..8 feed vectors 2, 3, 4, 5, 5, 6, 7, 8 and 9 in that order.
- R2: INT0 and INT1 use the 2-bit field `trig_cfg[2i+1:2i]`: 00 for a rising edge, 01 for a falling edge, 10 for a high level, 11 for a low level. A level request follows the pin with no latch and no added cycle.
- R3: INT2 and INT3 use the same field as an edge mask: bit 0 enables the rising edge and bit 1 the falling edge, and both may be set together. A detected edge sets a flag that shows as a request after the next clock edge.
- R4: A priority select of 0 gives the low level (1). A select of 1 gives the top level (3) on vectors 0 and 1, and the high level (2) on vectors 2..9.
- R5: A vector whose enable bit is 0 never produces a request.
- R6: Among enabled pending vectors, the highest level wins. On a tie, the lowest vector number wins.
- R7: `irq_req` is asserted only when the winner's level is strictly above `svc_level`. `irq_level` gives the level of the winner.
- R8: An acknowledge while `irq_req` is high makes `svc_level` equal to the acknowledged level on the next cycle, and it clears the winning pin's edge flag. An acknowledge while `irq_req` is low changes nothing.
- R9: A return drops `svc_level` to the next lower level still active, or to 0. A return in the same cycle as a taken acknowledge is ignored.
- R10: If a new enabled edge arrives in the cycle in which its flag is cleared by acknowledge, the flag stays set.
- R11: After reset, `irq_req` is 0 and `svc_level` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_int | input | 4 | External interrupt pins INT0..INT3 |
| periph_req | input | 9 | Peripheral request flags (mapping in R1) |
| trig_cfg | input | 8 | Trigger configuration, 2 bits per pin |
| vec_en | input | 10 | Per-vector enable |
| prio_sel | input | 10 | Per-vector priority select |
| ack | input | 1 | CPU entered the pending handler |
| ret | input | 1 | CPU returned from a handler |
| irq_req | output | 1 | Interrupt request to the CPU |
| irq_vec | output | 8 | Address of the winning vector |
| irq_level | output | 2 | Level of the winning request (level to push) |
| svc_level | output | 2 | Highest level now in service |

## Verification
Peripheral flags and level-triggered pins reach `irq_req`, `irq_vec` and `irq_level` through logic alone, so the bench checks them after a short settle within the same cycle in which it drives them. Edge-triggered pins pass through one register, so the bench first checks that no request appears before the clock edge, then checks one clock later that it does. `svc_level` moves one clock after an acknowledge or return strobe. Every strobe is driven on a falling edge and its result is read on the next falling edge.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int NVEC  = 10;
  localparam int NPIN  = 4;
  localparam int NPER  = 9;
  localparam int IDXW  = $clog2(NVEC);
  localparam int VADRW = 8;

  typedef logic [1:0] lvl_t;
  localparam lvl_t LV_NONE = 2'd0;
  localparam lvl_t LV_LOW  = 2'd1;
  localparam lvl_t LV_HIGH = 2'd2;
  localparam lvl_t LV_TOP  = 2'd3;

  // vectors are spaced 8 bytes apart, starting at 03H
  function automatic logic [VADRW-1:0] vec_addr(input int idx);
    return VADRW'(idx * 8 + 3);
  endfunction

  // vectors 0 and 1 choose low/top, the rest low/high
  function automatic lvl_t sel_level(input int idx, input logic sel);
    if (!sel) return LV_LOW;
    return (idx < 2) ? LV_TOP : LV_HIGH;
  endfunction

  // peripheral flag index -> vector number
  function automatic int per_vec(input int p);
    if (p == 0) return 2;
    if (p == 1) return 3;
    if (p <= 3) return p + 2;
    return p + 1;
  endfunction
endpackage

// File: rtl/irqc_pin_sense.sv
module irqc_pin_sense #(
  parameter bit LEVEL_OK = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin,
  input  logic [1:0] cfg,
  input  logic       clr,
  output logic       req,
  output logic       edge_hit
);
  logic pin_q, flag, rise_en, fall_en, lvl_mode, lvl_val;

  generate
    if (LEVEL_OK) begin : g_lvl
      assign lvl_mode = cfg[1];
      assign rise_en  = (cfg == 2'b00);
      assign fall_en  = (cfg == 2'b01);
      assign lvl_val  = cfg[0] ? ~pin : pin;
    end else begin : g_edge
      assign lvl_mode = 1'b0;
      assign rise_en  = cfg[0];
      assign fall_en  = cfg[1];
      assign lvl_val  = 1'b0;
    end
  endgenerate

  assign edge_hit = (rise_en & pin & ~pin_q) | (fall_en & ~pin & pin_q);
  assign req      = lvl_mode ? lvl_val : flag;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pin_q <= 1'b0;
      flag  <= 1'b0;
    end else begin
      pin_q <= pin;
      flag  <= ~lvl_mode & (edge_hit | (flag & ~clr));
    end
  end

  // R8
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr && !edge_hit |=> !flag);
  // R10
  edge_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    edge_hit && !lvl_mode |=> flag);
endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter
  import irqc_pkg::*;
(
  input  logic [NVEC-1:0] vreq,
  input  logic [NVEC-1:0] ven,
  input  logic [NVEC-1:0] psel,
  input  lvl_t            svc_level,
  output logic            win_req,
  output logic [IDXW-1:0] win_idx,
  output lvl_t            win_level
);
  always_comb begin
    win_level = LV_NONE;
    win_idx   = '0;
    // scan downward with >= so the lowest index wins a tie
    for (int v = NVEC - 1; v >= 0; v--) begin
      if (vreq[v] && ven[v] && (sel_level(v, psel[v]) >= win_level)) begin
        win_level = sel_level(v, psel[v]);
        win_idx   = IDXW'(v);
      end
    end
  end

  assign win_req = (win_level > svc_level);
endmodule

// File: rtl/irqc_svc_stack.sv
module irqc_svc_stack
  import irqc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  input  lvl_t take_level,
  input  logic ret,
  output lvl_t svc_level
);
  logic [2:0] active;  // bit k set: level k+1 in service

  always_comb begin
    if (active[2])      svc_level = LV_TOP;
    else if (active[1]) svc_level = LV_HIGH;
    else if (active[0]) svc_level = LV_LOW;
    else                svc_level = LV_NONE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= '0;
    end else if (take) begin
      active[2'(take_level - 2'd1)] <= 1'b1;
    end else if (ret && svc_level != LV_NONE) begin
      active[2'(svc_level - 2'd1)] <= 1'b0;
    end
  end

  // R8
  take_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> svc_level == $past(take_level));
  // R9
  ret_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ret && !take && svc_level != LV_NONE |=> svc_level < $past(svc_level));
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irqc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] pin_int,
  input  logic [NPER-1:0] periph_req,
  input  logic [2*NPIN-1:0] trig_cfg,
  input  logic [NVEC-1:0] vec_en,
  input  logic [NVEC-1:0] prio_sel,
  input  logic            ack,
  input  logic            ret,
  output logic            irq_req,
  output logic [VADRW-1:0] irq_vec,
  output logic [1:0]      irq_level,
  output logic [1:0]      svc_level
);
  logic [NPIN-1:0] pin_req, pin_clr, pin_edge;
  logic [NVEC-1:0] vreq;
  logic [IDXW-1:0] win_idx;
  lvl_t            win_level, cur_level;
  logic            win_req, take;

  generate
    for (genvar i = 0; i < NPIN; i++) begin : g_pin
      irqc_pin_sense #(.LEVEL_OK(i < 2)) u_sense (
        .clk(clk), .rst_n(rst_n), .pin(pin_int[i]),
        .cfg(trig_cfg[2*i+1:2*i]), .clr(pin_clr[i]),
        .req(pin_req[i]), .edge_hit(pin_edge[i]));
      assign pin_clr[i] = take && (win_idx == IDXW'(i));
    end
  endgenerate

  always_comb begin
    vreq = '0;
    vreq[NPIN-1:0] = pin_req;
    for (int p = 0; p < NPER; p++)
      if (periph_req[p]) vreq[per_vec(p)] = 1'b1;
  end

  irqc_arbiter u_arb (
    .vreq(vreq), .ven(vec_en), .psel(prio_sel), .svc_level(cur_level),
    .win_req(win_req), .win_idx(win_idx), .win_level(win_level));

  assign take = ack && win_req;

  irqc_svc_stack u_stack (
    .clk(clk), .rst_n(rst_n), .take(take), .take_level(win_level),
    .ret(ret), .svc_level(cur_level));

  assign irq_req   = win_req;
  assign irq_vec   = vec_addr(int'(win_idx));
  assign irq_level = win_level;
  assign svc_level = cur_level;

  // R7
  above_svc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> irq_level > svc_level);
  // R1
  vec_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> irq_vec[2:0] == 3'd3 && irq_vec <= 8'h4B);
  // R8
  idle_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack && !irq_req && !ret |=> $stable(svc_level));
  // R11
  reset_chk: assert property (@(posedge clk)
    !rst_n |=> svc_level == 2'd0);
endmodule

// File: tb/tb_irq_ctrl.sv
module tb_irq_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] pin_int = '0;
  logic [8:0] periph_req = '0;
  logic [7:0] trig_cfg = '0;
  logic [9:0] vec_en = '1;
  logic [9:0] prio_sel = '0;
  logic       ack = 1'b0, ret = 1'b0;
  logic       irq_req;
  logic [7:0] irq_vec;
  logic [1:0] irq_level, svc_level;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;  // 125 MHz

  irq_ctrl dut (.*);

  task automatic step(); @(negedge clk); endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic chk_irq(input string tag, input int vec, input int lvl);
    #1;
    chk({tag, " req"}, int'(irq_req), 1);
    chk({tag, " vec"}, int'(irq_vec), vec * 8 + 3);
    chk({tag, " lvl"}, int'(irq_level), lvl);
  endtask

  task automatic chk_none(input string tag);
    #1; chk({tag, " no req"}, int'(irq_req), 0);
  endtask

  task automatic do_ack(); ack = 1; step(); ack = 0; endtask
  task automatic do_ret(); ret = 1; step(); ret = 0; endtask

  task automatic t_reset();
    chk("R11 req", int'(irq_req), 0);
    chk("R11 svc", int'(svc_level), 0);
  endtask

  task automatic t_map();
    int pv[9] = '{2, 3, 4, 5, 5, 6, 7, 8, 9};
    for (int p = 0; p < 9; p++) begin
      periph_req = 9'(1 << p);
      chk_irq("R1 map", pv[p], 1);
    end
    periph_req = '0;
  endtask

  task automatic t_int01();
    pin_int[0] = 1; chk_none("R3 edge latched later");
    step(); chk_irq("R2 int0 rise", 0, 1);
    pin_int[0] = 0; step(); chk_irq("R2 rise kept", 0, 1);
    do_ack(); chk("R8 svc", int'(svc_level), 1);
    do_ret(); chk("R9 svc", int'(svc_level), 0);
    chk_none("R8 flag cleared");
    trig_cfg[1:0] = 2'b01;
    pin_int[0] = 1; step(); chk_none("R2 fall ignores rise");
    pin_int[0] = 0; step(); chk_irq("R2 int0 fall", 0, 1);
    do_ack(); do_ret(); chk_none("R8 fall cleared");
    trig_cfg[1:0] = 2'b10; step(); chk_none("R2 high idle");
    pin_int[0] = 1; chk_irq("R2 int0 high", 0, 1);
    pin_int[0] = 0; chk_none("R2 high not latched");
    trig_cfg[3:2] = 2'b11; chk_irq("R2 int1 low", 1, 1);
    pin_int[1] = 1; chk_none("R2 low released");
    step(); trig_cfg = '0; pin_int[1] = 0; step(); step();
    chk_none("R2 cleanup");
  endtask

  task automatic t_int23();
    trig_cfg[5:4] = 2'b11;
    pin_int[2] = 1; step(); chk_irq("R3 int2 rise", 2, 1);
    do_ack(); do_ret();
    pin_int[2] = 0; step(); chk_irq("R3 int2 fall", 2, 1);
    do_ack(); do_ret(); chk_none("R3 int2 cleared");
    trig_cfg[7:6] = 2'b10;
    pin_int[3] = 1; step(); chk_none("R3 int3 rise masked");
    pin_int[3] = 0; step(); chk_irq("R3 int3 fall", 3, 1);
    do_ack(); do_ret(); trig_cfg = '0;
  endtask

  task automatic t_prio();
    periph_req[8] = 1; prio_sel[9] = 1;
    trig_cfg[1:0] = 2'b10; pin_int[0] = 1;
    chk_irq("R6 high beats low", 9, 2);
    prio_sel[0] = 1; chk_irq("R4 int0 top", 0, 3);
    pin_int[0] = 0; periph_req = '0; prio_sel = '0;
    periph_req[5] = 1; periph_req[7] = 1;
    chk_irq("R6 tie lowest", 6, 1);
    prio_sel[8] = 1; chk_irq("R4 high select", 8, 2);
    periph_req = '0; prio_sel = '0; step(); trig_cfg = '0; step();
  endtask

  task automatic t_disable();
    periph_req[6] = 1; vec_en[7] = 0; chk_none("R5 disabled");
    vec_en[7] = 1; chk_irq("R5 enabled", 7, 1);
    periph_req = '0;
  endtask

  task automatic t_nest();
    periph_req[2] = 1; step(); do_ack();
    chk("R8 svc low", int'(svc_level), 1);
    chk_none("R7 equal level blocked");
    periph_req[6] = 1; prio_sel[7] = 1; chk_irq("R7 high over low", 7, 2);
    do_ack(); chk("R8 svc high", int'(svc_level), 2);
    chk_none("R7 blocked at high");
    trig_cfg[1:0] = 2'b10; prio_sel[0] = 1; pin_int[0] = 1;
    chk_irq("R7 top over high", 0, 3);
    do_ack(); chk("R8 svc top", int'(svc_level), 3);
    pin_int[0] = 0; periph_req[6] = 0; prio_sel = '0;
    do_ret(); chk("R9 back to high", int'(svc_level), 2);
    do_ret(); chk("R9 back to low", int'(svc_level), 1);
    do_ret(); chk("R9 idle", int'(svc_level), 0);
    chk_irq("R7 low resumes", 4, 1);
    periph_req = '0; trig_cfg = '0; step();
  endtask

  task automatic t_ack_idle();
    do_ack(); chk("R8 idle ack", int'(svc_level), 0);
  endtask

  task automatic t_ack_ret();
    periph_req[2] = 1; step(); do_ack();
    periph_req[2] = 0; periph_req[6] = 1; prio_sel[7] = 1;
    ack = 1; ret = 1; step(); ack = 0; ret = 0;
    chk("R9 ret ignored with ack", int'(svc_level), 2);
    periph_req = '0; prio_sel = '0;
    do_ret(); chk("R9 low kept", int'(svc_level), 1);
    do_ret(); chk("R9 cleared", int'(svc_level), 0);
  endtask

  task automatic t_setclr();
    trig_cfg[5:4] = 2'b01;
    pin_int[2] = 1; step(); chk_irq("R10 first edge", 2, 1);
    pin_int[2] = 0; step();
    ack = 1; pin_int[2] = 1; step(); ack = 0;
    chk("R10 svc", int'(svc_level), 1);
    do_ret(); chk_irq("R10 flag kept", 2, 1);
    do_ack(); do_ret(); chk_none("R10 final clear");
    trig_cfg = '0;
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1; step();
    t_reset();
    t_map();
    t_int01();
    t_int23();
    t_prio();
    t_disable();
    t_nest();
    t_ack_idle();
    t_ack_ret();
    t_setclr();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule